// File: doc/BRIEF.md
# Request Admission Filter by Role and Mains Sync

This block sits behind a local frame decoder in a power-line modem. Each request that has already been parsed and checked arrives as a request class and an 8-bit identifier, together with a one-cycle valid strobe. One cycle later the block answers with exactly one pulse, either accept or reject. The answer depends on the modem's configured role, on whether the modem is currently locked to the mains, and on the class and identifier of the request.

The role is loaded from a role input when a write strobe is high. The synchronisation flag is registered from a live input on every clock. A relaxation input enables a newer firmware behaviour in which configuration writes are accepted in any role. While the role is monitor and the modem is synchronised, a spy-enable flag stays high so that observed traffic can be forwarded.

Top module: `req_admit_filter`

## Requirements
- R1: After reset the role is unconfigured and the sync flag is clear. acceptPulse, rejectPulse and spyEnable are low. A database request is then rejected.
- R2: A request with reqValid high at a clock edge gives exactly one pulse, acceptPulse or rejectPulse, in the following cycle. With reqValid low no pulse appears in the following cycle. Back-to-back requests each get their own pulse.
- R3: When roleWr is high at an edge, the role is loaded from roleIn, encoded 0 = unconfigured, 1 = master, 2 = slave, 3 = monitor. The sync flag takes the value of syncIn at every edge. A request is judged by the role and sync flag held before that same edge.
- R4: In the unconfigured role, the accepted requests are the local-control requests reset, test-mode, config-write and new-config-write. Every database (class 1), MAC (class 2) and ISA (class 3) request is rejected. Local-control is class 0.
- R5: In the master role, local-control reset and every database, MAC and ISA request are accepted. Test-mode is rejected.
- R6: A slave whose sync flag is clear accepts local-control reset and database requests. It rejects MAC, ISA and test-mode requests.
- R7: A slave whose sync flag is set accepts the same set as a master.
- R8: A monitor accepts local-control reset and database requests, and rejects MAC, ISA and test-mode requests whatever the sync flag. spyEnable is high exactly while the role is monitor and the sync flag is set.
- R9: With relaxCfg high, config-write and new-config-write are accepted in every role. With relaxCfg low, they are accepted only in the unconfigured role.
- R10: The local-control identifiers are reset = 0x20, test-mode = 0x21, config-write = 0x31 and new-config-write = 0x71. Any other local-control identifier is rejected in every role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| roleWr | input | 1 | Load strobe for roleIn |
| roleIn | input | 2 | Role code to load |
| syncIn | input | 1 | Live mains-lock indication |
| relaxCfg | input | 1 | Allows config writes in any role |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqClass | input | 2 | Request class: 0 local-control, 1 database, 2 MAC, 3 ISA |
| reqId | input | 8 | Request identifier |
| acceptPulse | output | 1 | One-cycle accept answer |
| rejectPulse | output | 1 | One-cycle reject answer |
| spyEnable | output | 1 | Monitor role and synchronised |

## Verification
The assertions take for granted that reqClass and reqId are stable and meaningful in every cycle where reqValid is high. They also assume that relaxCfg does not change in the cycle of a request. The bench changes all inputs only on the falling edge and holds them for a whole cycle. It walks every role, both sync states, both relaxCfg settings, every class and a set of identifiers that includes a value that is not defined. A behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/admit_pkg.sv
package admit_pkg;
  typedef enum logic [1:0] {
    ROLE_NOTSET  = 2'd0,
    ROLE_MASTER  = 2'd1,
    ROLE_SLAVE   = 2'd2,
    ROLE_MONITOR = 2'd3
  } role_e;

  typedef enum logic [1:0] {
    CLS_LOCAL = 2'd0,
    CLS_DB    = 2'd1,
    CLS_MAC   = 2'd2,
    CLS_ISA   = 2'd3
  } class_e;

  // Strobes and permissions passed from control to datapath
  typedef struct packed {
    logic evalReq;   // a request is being judged this cycle
    logic cfgOpen;   // config writes permitted
    logic testOpen;  // test-mode permitted
    logic dbOpen;    // database class permitted
    logic linkOpen;  // MAC and ISA classes permitted
    logic spyOn;     // monitor role and synchronised
  } ctrlStrobe_t;
endpackage

// File: rtl/admit_ctrl.sv
module admit_ctrl
  import admit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        roleWr,
  input  logic [1:0]  roleIn,
  input  logic        syncIn,
  input  logic        relaxCfg,
  input  logic        reqValid,
  output role_e       roleQ,
  output logic        syncQ,
  output ctrlStrobe_t strobes
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roleQ <= ROLE_NOTSET;
      syncQ <= 1'b0;
    end else begin
      syncQ <= syncIn;
      if (roleWr) roleQ <= role_e'(roleIn);
    end
  end

  logic isNotSet, isMaster, isSlave, isMonitor;
  assign isNotSet  = (roleQ == ROLE_NOTSET);
  assign isMaster  = (roleQ == ROLE_MASTER);
  assign isSlave   = (roleQ == ROLE_SLAVE);
  assign isMonitor = (roleQ == ROLE_MONITOR);

  always_comb begin
    strobes.evalReq  = reqValid;
    strobes.cfgOpen  = isNotSet || relaxCfg;
    strobes.testOpen = isNotSet;
    strobes.dbOpen   = !isNotSet;
    strobes.linkOpen = isMaster || (isSlave && syncQ);
    strobes.spyOn    = isMonitor && syncQ;
  end
endmodule

// File: rtl/admit_datapath.sv
module admit_datapath
  import admit_pkg::*;
#(
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] ID_RESET  = 8'h20,
  parameter logic [ID_W-1:0] ID_TEST   = 8'h21,
  parameter logic [ID_W-1:0] ID_CFG    = 8'h31,
  parameter logic [ID_W-1:0] ID_CFGNEW = 8'h71
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobes,
  input  logic [1:0]      reqClass,
  input  logic [ID_W-1:0] reqId,
  output logic            acceptPulse,
  output logic            rejectPulse,
  output logic            spyEnable
);
  logic localOk, grant;

  always_comb begin
    localOk = 1'b0;
    if (reqId == ID_RESET)                          localOk = 1'b1;
    else if (reqId == ID_TEST)                      localOk = strobes.testOpen;
    else if (reqId == ID_CFG || reqId == ID_CFGNEW) localOk = strobes.cfgOpen;
  end

  always_comb begin
    unique case (class_e'(reqClass))
      CLS_LOCAL: grant = localOk;
      CLS_DB:    grant = strobes.dbOpen;
      CLS_MAC,
      CLS_ISA:   grant = strobes.linkOpen;
      default:   grant = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptPulse <= 1'b0;
      rejectPulse <= 1'b0;
    end else begin
      acceptPulse <= strobes.evalReq && grant;
      rejectPulse <= strobes.evalReq && !grant;
    end
  end

  assign spyEnable = strobes.spyOn;
endmodule

// File: rtl/req_admit_filter.sv
module req_admit_filter
  import admit_pkg::*;
#(
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] ID_RESET  = 8'h20,
  parameter logic [ID_W-1:0] ID_TEST   = 8'h21,
  parameter logic [ID_W-1:0] ID_CFG    = 8'h31,
  parameter logic [ID_W-1:0] ID_CFGNEW = 8'h71
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            roleWr,
  input  logic [1:0]      roleIn,
  input  logic            syncIn,
  input  logic            relaxCfg,
  input  logic            reqValid,
  input  logic [1:0]      reqClass,
  input  logic [ID_W-1:0] reqId,
  output logic            acceptPulse,
  output logic            rejectPulse,
  output logic            spyEnable
);
  role_e       roleQ;
  logic        syncQ;
  ctrlStrobe_t strobes;

  admit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .roleWr(roleWr), .roleIn(roleIn),
    .syncIn(syncIn), .relaxCfg(relaxCfg), .reqValid(reqValid),
    .roleQ(roleQ), .syncQ(syncQ), .strobes(strobes)
  );

  admit_datapath #(
    .ID_W(ID_W), .ID_RESET(ID_RESET), .ID_TEST(ID_TEST),
    .ID_CFG(ID_CFG), .ID_CFGNEW(ID_CFGNEW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqClass(reqClass),
    .reqId(reqId), .acceptPulse(acceptPulse), .rejectPulse(rejectPulse),
    .spyEnable(spyEnable)
  );
endmodule

// File: rtl/admit_checker.sv
module admit_checker #(
  parameter int ID_W = 8,
  parameter logic [ID_W-1:0] ID_RESET = 8'h20,
  parameter logic [ID_W-1:0] ID_CFG   = 8'h31
) (
  input logic            clk,
  input logic            rstN,
  input logic            relaxCfg,
  input logic            reqValid,
  input logic [1:0]      reqClass,
  input logic [ID_W-1:0] reqId,
  input logic [1:0]      roleQ,
  input logic            syncQ,
  input logic            acceptPulse,
  input logic            rejectPulse,
  input logic            spyEnable
);
  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptPulse && rejectPulse));

  p_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (acceptPulse || rejectPulse));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!acceptPulse && !rejectPulse));

  p_notset_class_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && roleQ == 2'd0 && reqClass != 2'd0) |=> rejectPulse);

  p_unsync_slave_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && roleQ == 2'd2 && !syncQ && reqClass[1]) |=> rejectPulse);

  p_monitor_link_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && roleQ == 2'd3 && reqClass[1]) |=> rejectPulse);

  p_spy_r8: assert property (@(posedge clk) disable iff (!rstN)
    spyEnable |-> (roleQ == 2'd3 && syncQ));

  p_relax_cfg_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && relaxCfg && reqClass == 2'd0 && reqId == ID_CFG) |=> acceptPulse);

  p_reset_id_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqClass == 2'd0 && reqId == ID_RESET) |=> acceptPulse);
endmodule

bind req_admit_filter admit_checker #(
  .ID_W(ID_W), .ID_RESET(ID_RESET), .ID_CFG(ID_CFG)
) u_chk (
  .clk(clk), .rstN(rstN), .relaxCfg(relaxCfg), .reqValid(reqValid),
  .reqClass(reqClass), .reqId(reqId), .roleQ(roleQ), .syncQ(syncQ),
  .acceptPulse(acceptPulse), .rejectPulse(rejectPulse), .spyEnable(spyEnable)
);

// File: tb/req_admit_filter_tb.sv
module req_admit_filter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic roleWr = 1'b0;
  logic [1:0] roleIn = 2'd0;
  logic syncIn = 1'b0;
  logic relaxCfg = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqClass = 2'd0;
  logic [7:0] reqId = 8'd0;
  logic acceptPulse, rejectPulse, spyEnable;

  int checks = 0;
  int errors = 0;
  int mRole = 0;
  int mSync = 0;

  always #10 clk = ~clk;

  req_admit_filter u_dut (
    .clk(clk), .rstN(rstN), .roleWr(roleWr), .roleIn(roleIn),
    .syncIn(syncIn), .relaxCfg(relaxCfg), .reqValid(reqValid),
    .reqClass(reqClass), .reqId(reqId), .acceptPulse(acceptPulse),
    .rejectPulse(rejectPulse), .spyEnable(spyEnable)
  );

  function automatic bit modelGrant(int role, int sync, bit relax, int cls, int id);
    if (cls == 0) begin
      if (id == 'h20) return 1;
      if (id == 'h21) return role == 0;
      if (id == 'h31 || id == 'h71) return role == 0 || relax;
      return 0;
    end
    if (cls == 1) return role != 0;
    return role == 1 || (role == 2 && sync == 1);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle from the falling edge, then compare at the next falling edge
  task automatic step(string tag, bit wr, int role, bit sync, bit relax,
                      bit valid, int cls, int id);
    bit g;
    roleWr = wr; roleIn = role[1:0]; syncIn = sync; relaxCfg = relax;
    reqValid = valid; reqClass = cls[1:0]; reqId = id[7:0];
    g = modelGrant(mRole, mSync, relax, cls, id);
    @(posedge clk);
    if (wr) mRole = role;
    mSync = sync;
    @(negedge clk);
    check(tag, "accept", acceptPulse, valid && g);
    check(tag, "reject", rejectPulse, valid && !g);
    check(tag, "spy", spyEnable, mRole == 3 && mSync == 1);
  endtask

  initial begin
    #(20 * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ids[5];
    string tg;
    ids[0] = 'h20; ids[1] = 'h21; ids[2] = 'h31; ids[3] = 'h71; ids[4] = 'h55;
    repeat (2) @(negedge clk);
    check("R1", "accept at reset", acceptPulse, 0);
    check("R1", "reject at reset", rejectPulse, 0);
    check("R1", "spy at reset", spyEnable, 0);
    rstN = 1'b1;
    @(negedge clk);
    step("R1", 0, 0, 0, 0, 1, 1, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 'h20);
    step("R2", 0, 0, 0, 0, 1, 0, 'h20);
    step("R2", 0, 0, 0, 0, 1, 2, 0);
    step("R2", 0, 0, 0, 0, 0, 2, 0);
    // Same-edge role load and request: judged by old role (R3)
    step("R3", 1, 1, 0, 0, 1, 2, 0);
    step("R3", 0, 1, 0, 0, 1, 2, 0);
    // Sync taken at edge, request in same cycle sees old flag (R3)
    step("R3", 1, 2, 1, 0, 1, 3, 0);
    step("R3", 0, 2, 1, 0, 1, 3, 0);
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < 2; s++) begin
        step("R3", 1, r, s[0], 0, 0, 0, 0);
        step("R3", 0, r, s[0], 0, 0, 0, 0);
        for (int x = 0; x < 2; x++) begin
          for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 5; k++) begin
              if (c != 0 && k != 0) continue;
              if (c == 0 && (k == 2 || k == 3)) tg = "R9";
              else if (c == 0 && k == 4) tg = "R10";
              else if (r == 0) tg = "R4";
              else if (r == 1) tg = "R5";
              else if (r == 2) tg = (s == 1) ? "R7" : "R6";
              else tg = "R8";
              step(tg, 0, r, s[0], x[0], 1, c, ids[k]);
            end
          end
        end
      end
    end
    // Spy follows sync while monitor (R8)
    step("R8", 1, 3, 1, 0, 0, 0, 0);
    step("R8", 0, 3, 0, 0, 0, 0, 0);
    step("R8", 0, 3, 1, 0, 1, 1, 0);
    step("R8", 1, 1, 1, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule